// File: doc/BRIEF.md
# Output Compare Port Controller

This block sits beside a microcontroller timer and turns compare-match strobes from five output compare channels into action pulses, flag-set requests and updates of an 8-bit output port. The comparators and the counter live elsewhere. This block only receives one match strobe per channel and reports what each channel should do.

Three byte-wide registers sit on a simple synchronous CPU bus:
- a force strobe register, which makes a channel act as if it had matched, without raising its status flag;
- a mask register;
- a data register.

Channel 1 is special. Whenever it acts, whether from a real match or a force, every port pin whose mask bit is set copies the matching data bit. Every other pin keeps its value.

All outputs are registered. Every reaction appears one clock after the cycle that caused it, and reset is synchronous and active high.

Top module: `ocp_top`

## Requirements
- R1: A bus write to the force register (address 1) with bit 7, 6, 5, 4 or 3 set pulses `act_pulse` bit 0, 1, 2, 3 or 4 respectively (channels 1 to 5) for exactly one cycle. The pulse appears one clock after the write, and `flag_req` stays low for a forced channel.
- R2: Force bits written as 0 cause no action pulse, no flag request and no port change.
- R3: A high `cmp_match` bit makes the same bit of `flag_req` and of `act_pulse` high together, one clock later, for one cycle per strobe cycle.
- R4: A match and a force on the same channel in the same cycle give a single one-cycle action pulse, and the flag request is still raised.
- R5: When channel 1 acts, each port bit 7 to 3 whose mask bit is 1 takes the data register bit of the same position, and each port bit whose mask bit is 0 keeps its value. The new port value appears in the same cycle as the channel 1 action pulse.
- R6: The port holds its value in every cycle without a channel 1 action, including cycles in which only channels 2 to 5 act.
- R7: Bits 2 to 0 of the mask and data registers read as 0 and ignore writes. Port bits 2 to 0 are always 0.
- R8: The force register (address 1) and the unused address 0 always read as 0.
- R9: After reset, the mask and data registers, the port, `act_pulse`, `flag_req` and `bus_rdata` are all 0.
- R10: A read (`bus_sel`=1, `bus_wr`=0) returns the mask register at address 2 and the data register at address 3 on `bus_rdata` one clock later. In a cycle without a read, `bus_rdata` is 0.
- R11: A channel 1 action in the same cycle as a write to the mask or data register uses the old register contents. The new contents apply to later actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 1 force, 2 mask, 3 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read |
| cmp_match | input | 5 | Compare match strobes, bit 0 = channel 1 |
| act_pulse | output | 5 | Per-channel action pulses |
| flag_req | output | 5 | Per-channel flag-set requests |
| port_q | output | 8 | Output port driven by channel 1 |

## Verification
A corrupted mask or data bit stays hidden until the next channel 1 action. At that point it shows on `port_q` in the same cycle as the pulse. A register read also exposes it one clock after the read. A wrong pulse or flag register shows on `act_pulse` or `flag_req` one clock after the offending strobe, and a flag raised for a force shows as `flag_req` high without a match. The bench therefore pairs every stimulus cycle with an expected port, pulse, flag and read value for the following cycle.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_NONE  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FORCE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 2'd3;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_READ  = 2'd1,
    BUS_WRITE = 2'd2
  } bus_op_e;
endpackage

// File: rtl/ocp_regs.sv
module ocp_regs
  import ocp_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned N_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     mask_q,
  output logic [DW-1:0]     data_q,
  output logic [DW-1:0]     rdata_q
);
  localparam int unsigned LSB = DW - N_CH;

  logic wr_mask, wr_data;
  assign wr_mask = (op == BUS_WRITE) && (addr == ADDR_MASK);
  assign wr_data = (op == BUS_WRITE) && (addr == ADDR_DATA);

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b >= LSB) begin : g_impl
      always_ff @(posedge clk) begin
        if (rst) begin
          mask_q[b] <= 1'b0;
          data_q[b] <= 1'b0;
        end else begin
          if (wr_mask) mask_q[b] <= wdata[b];
          if (wr_data) data_q[b] <= wdata[b];
        end
      end
    end else begin : g_none
      assign mask_q[b] = 1'b0;
      assign data_q[b] = 1'b0;
    end
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    unique case (addr)
      ADDR_MASK: rd_mux = mask_q;
      ADDR_DATA: rd_mux = data_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (op == BUS_READ) rdata_q <= rd_mux;
    else rdata_q <= '0;
  end

  if (LSB > 0) begin : g_chk
    AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
      rdata_q[LSB-1:0] == '0); // R7
  end
  AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(op) != BUS_READ |-> rdata_q == '0); // R10
endmodule

// File: rtl/ocp_force.sv
module ocp_force
  import ocp_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned N_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [N_CH-1:0]   match,
  output logic [N_CH-1:0]   act_now,
  output logic [N_CH-1:0]   act_q,
  output logic [N_CH-1:0]   flag_q
);
  logic force_hit;
  assign force_hit = (op == BUS_WRITE) && (addr == ADDR_FORCE);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic forced;
    assign forced     = force_hit & wdata[DW-1-c];
    assign act_now[c] = forced | match[c];

    always_ff @(posedge clk) begin
      if (rst) begin
        act_q[c]  <= 1'b0;
        flag_q[c] <= 1'b0;
      end else begin
        act_q[c]  <= act_now[c];
        flag_q[c] <= match[c];
      end
    end
  end

  AST_FLAG_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
    (flag_q & ~act_q) == '0); // R3
  AST_FLAG_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> flag_q == $past(match)); // R1
endmodule

// File: rtl/ocp_port.sv
module ocp_port #(
  parameter int unsigned DW   = 8,
  parameter int unsigned N_CH = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act1_now,
  input  logic          act1_q,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] port_q
);
  localparam int unsigned LSB = DW - N_CH;

  for (genvar b = 0; b < DW; b++) begin : g_pin
    if (b >= LSB) begin : g_drv
      always_ff @(posedge clk) begin
        if (rst) port_q[b] <= 1'b0;
        else if (act1_now && mask[b]) port_q[b] <= data[b];
      end
    end else begin : g_undriven
      assign port_q[b] = 1'b0;
    end
  end

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !act1_q |-> $stable(port_q)); // R6
  AST_PORT_UPDATE: assert property (@(posedge clk) disable iff (rst)
    act1_q |-> port_q == (($past(port_q) & ~$past(mask)) | ($past(data) & $past(mask)))); // R5
  if (LSB > 0) begin : g_chk
    AST_PORT_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
      port_q[LSB-1:0] == '0); // R7
  end
endmodule

// File: rtl/ocp_top.sv
module ocp_top
  import ocp_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned N_CH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_CH-1:0]   cmp_match,
  output logic [N_CH-1:0]   act_pulse,
  output logic [N_CH-1:0]   flag_req,
  output logic [DW-1:0]     port_q
);
  bus_op_e op;
  always_comb begin
    if (!bus_sel)   op = BUS_IDLE;
    else if (bus_wr) op = BUS_WRITE;
    else            op = BUS_READ;
  end

  logic [DW-1:0]   mask_q, data_q;
  logic [N_CH-1:0] act_now;

  ocp_regs #(.DW(DW), .N_CH(N_CH)) u_regs (
    .clk(clk), .rst(rst), .op(op), .addr(bus_addr), .wdata(bus_wdata),
    .mask_q(mask_q), .data_q(data_q), .rdata_q(bus_rdata)
  );

  ocp_force #(.DW(DW), .N_CH(N_CH)) u_force (
    .clk(clk), .rst(rst), .op(op), .addr(bus_addr), .wdata(bus_wdata),
    .match(cmp_match), .act_now(act_now), .act_q(act_pulse), .flag_q(flag_req)
  );

  ocp_port #(.DW(DW), .N_CH(N_CH)) u_port (
    .clk(clk), .rst(rst), .act1_now(act_now[0]), .act1_q(act_pulse[0]),
    .mask(mask_q), .data(data_q), .port_q(port_q)
  );

  AST_FORCE_ZERO_NO_ACT: assert property (@(posedge clk) disable iff (rst)
    $past(cmp_match) == '0 && !($past(bus_sel) && $past(bus_wr)) |-> act_pulse == '0); // R2
endmodule

// File: tb/ocp_top_test.sv
`timescale 1ns/1ps
module ocp_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] cmp_match = '0;
  logic [4:0] act_pulse, flag_req;
  logic [7:0] port_q;

  always #2.5 clk = ~clk;

  ocp_top uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_match(cmp_match), .act_pulse(act_pulse), .flag_req(flag_req),
    .port_q(port_q)
  );

  typedef struct {
    logic [7:0] port;
    logic [7:0] rdata;
    logic [4:0] act;
    logic [4:0] flag;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_bad = 0;
  logic [7:0] m_mask = '0, m_data = '0, m_port = '0;

  task automatic cmp(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push what the ports must show after the edge.
  task automatic step(logic sel, logic wr, logic [1:0] addr, logic [7:0] wd,
                      logic [4:0] match, string tag);
    exp_t e;
    logic [4:0] frc;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd; cmp_match = match;
    frc = (sel && wr && addr == 2'd1) ? {wd[3], wd[4], wd[5], wd[6], wd[7]} : 5'd0;
    e.act  = match | frc;
    e.flag = match;
    if (e.act[0]) m_port = (m_port & ~m_mask) | (m_data & m_mask);
    e.port = m_port;
    if (sel && !wr) e.rdata = (addr == 2'd2) ? m_mask : (addr == 2'd3) ? m_data : 8'h00;
    else e.rdata = 8'h00;
    e.tag = tag;
    if (sel && wr && addr == 2'd2) m_mask = wd & 8'hF8;
    if (sel && wr && addr == 2'd3) m_data = wd & 8'hF8;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "port", port_q, e.port);
        cmp(e.tag, "rdata", bus_rdata, e.rdata);
        cmp(e.tag, "act", {3'b0, act_pulse}, {3'b0, e.act});
        cmp(e.tag, "flag", {3'b0, flag_req}, {3'b0, e.flag});
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R9", "port", port_q, 8'h00);
    cmp("R9", "act", {3'b0, act_pulse}, 8'h00);
    cmp("R9", "flag", {3'b0, flag_req}, 8'h00);
    cmp("R9", "rdata", bus_rdata, 8'h00);
    @(negedge clk) rst = 1'b0;
    step(1, 0, 2'd2, 8'h00, 5'd0, "R9");            // mask reads 0
    step(1, 0, 2'd3, 8'h00, 5'd0, "R9");            // data reads 0
    step(1, 1, 2'd2, 8'hFF, 5'd0, "R7");            // low bits ignored
    step(1, 0, 2'd2, 8'h00, 5'd0, "R10");           // expect F8
    step(1, 1, 2'd3, 8'hA7, 5'd0, "R7");
    step(1, 0, 2'd3, 8'h00, 5'd0, "R10");           // expect A0
    step(1, 0, 2'd1, 8'h00, 5'd0, "R8");            // force reads 0
    step(1, 0, 2'd0, 8'h00, 5'd0, "R8");            // unused address reads 0
    step(0, 0, 2'd0, 8'h00, 5'd0, "R10");           // idle rdata 0
    step(1, 1, 2'd1, 8'h80, 5'd0, "R1");            // force ch1, no flag, port A0
    step(0, 0, 2'd0, 8'h00, 5'd0, "R1");            // pulse lasts one cycle
    step(1, 1, 2'd1, 8'h78, 5'd0, "R6");            // force ch2..5, port holds
    step(1, 1, 2'd1, 8'h00, 5'd0, "R2");            // zero force: nothing
    step(1, 1, 2'd1, 8'h07, 5'd0, "R2");            // unimplemented force bits
    step(1, 1, 2'd3, 8'h58, 5'd0, "R5");
    step(0, 0, 2'd0, 8'h00, 5'b00001, "R3");        // match ch1 -> port 58, flag
    step(0, 0, 2'd0, 8'h00, 5'b10110, "R3");        // other channels, port holds
    step(1, 1, 2'd2, 8'h30, 5'd0, "R5");
    step(1, 1, 2'd3, 8'hFF, 5'd0, "R5");
    step(0, 0, 2'd0, 8'h00, 5'b00001, "R5");        // partial mask -> 78
    step(1, 1, 2'd1, 8'h80, 5'b00001, "R4");        // match + force together
    step(1, 1, 2'd1, 8'hF8, 5'b11111, "R4");
    step(1, 1, 2'd3, 8'h00, 5'b00001, "R11");       // old data FF used
    step(0, 0, 2'd0, 8'h00, 5'b00001, "R11");       // new data 00 -> 48
    step(1, 1, 2'd2, 8'hC8, 5'b00001, "R11");       // old mask 30 used
    step(1, 1, 2'd1, 8'h80, 5'd0, "R11");           // new mask C8 -> 00
    step(0, 0, 2'd0, 8'h00, 5'd0, "R6");
    step(0, 0, 2'd0, 8'h00, 5'b11110, "R6");
    step(0, 0, 2'd0, 8'h00, 5'd0, "R7");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule